// File: doc/BRIEF.md
# Dual-Byte Character Fetch Serializer

This block lets a display timing generator that counts a fixed number of character slots per line show twice that many columns, and it needs no faster video memory to do so. The memory has two banks side by side on a 16-bit data path, so one fetch returns two character codes. Each slot of the timing generator opens with a one-cycle strobe, together with that slot's address and display enable. The block captures the whole 16-bit word on that strobe. It sends the low byte to character lookup during the first half of the slot. A holding latch keeps the high byte, which goes out during the second half. With a 40-slot line, this yields 80 columns.

Each emitted character carries a 7-bit glyph code and a reverse-video flag. The flag is taken from bit 7 of the byte and goes to the downstream inverter. Each character also carries its screen column and a valid flag. The font lookup, pixel shifter and inverter sit downstream and are not part of the block.

Top module: `dual_char_serializer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, char_valid is 0 and char_glyph, char_rev and char_col are all 0.
- R2: Consider a strobe taken with display enable high. For the next HALF cycles, char_valid is 1 and char_glyph equals bits 6:0 of the captured word. char_col equals 2*slot_addr, and is even.
- R3: In the HALF cycles that follow, the block shows the high byte: char_glyph equals bits 14:8 of the captured word and char_col equals 2*slot_addr+1.
- R4: char_rev equals bit 7 of the byte currently shown, which is bit 7 in the first half and bit 15 in the second half.
- R5: A strobe taken with display enable low clears both latches. For that slot, char_valid, char_glyph, char_rev and char_col are all 0.
- R6: Changes on mem_data, slot_addr or disp_en between strobes have no effect on the outputs.
- R7: If no new strobe arrives within SLOT_CYC cycles of the last one, char_valid falls and every output reads 0 until the next enabled strobe.
- R8: A strobe that arrives before the current slot has ended restarts output at the low byte of the newly captured word, in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_stb | input | 1 | One-cycle start-of-slot strobe from the timing generator |
| slot_addr | input | AW | Slot index within the line |
| disp_en | input | 1 | Display enable, sampled with the strobe |
| mem_data | input | 16 | Two character codes; low byte is shown first |
| char_valid | output | 1 | A character is being presented |
| char_glyph | output | 7 | Character code for font lookup |
| char_rev | output | 1 | Reverse-video flag for the inverter |
| char_col | output | AW+1 | Screen column of the presented character |

## Verification
Two situations are hard to reach through the ports. One is a strobe that lands in the middle of a slot. The other is a slot that runs out with no new strobe. Both need the strobe's timing to break the steady cadence of the line, so the bench runs back-to-back slots for a long sweep and then, on purpose, cuts one slot short and lets another slot lapse. During the sweep, the bench scrambles mem_data and slot_addr right after each strobe. This shows that the latches, and not the live bus, drive every half-slot. Across the sweep, each of the 256 byte values appears in both the low position and the high position.

// File: rtl/dual_char_serializer.sv
module dual_char_serializer #(
  parameter int AW       = 6,
  parameter int SLOT_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_stb,
  input  logic [AW-1:0] slot_addr,
  input  logic          disp_en,
  input  logic [15:0]   mem_data,
  output logic          char_valid,
  output logic [6:0]    char_glyph,
  output logic          char_rev,
  output logic [AW:0]   char_col
);
  localparam int HALF = SLOT_CYC / 2;
  localparam int CW   = $clog2(SLOT_CYC + 1);

  logic [7:0]    lo_q, hi_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt;
  logic          live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      addr_q <= '0;
      cnt    <= CW'(SLOT_CYC);
      live   <= 1'b0;
    end else if (slot_stb) begin
      cnt <= '0;
      if (disp_en) begin
        lo_q   <= mem_data[7:0];
        hi_q   <= mem_data[15:8];
        addr_q <= slot_addr;
        live   <= 1'b1;
      end else begin
        lo_q   <= '0;
        hi_q   <= '0;
        addr_q <= '0;
        live   <= 1'b0;
      end
    end else if (cnt != CW'(SLOT_CYC)) begin
      cnt <= cnt + 1'b1;
      if (cnt == CW'(SLOT_CYC - 1)) begin
        live <= 1'b0;
        lo_q <= '0;
        hi_q <= '0;
      end
    end
  end

  wire       second = (cnt >= CW'(HALF));
  wire [7:0] shown  = second ? hi_q : lo_q;

  assign char_valid = live;
  assign char_glyph = live ? shown[6:0] : 7'd0;
  assign char_rev   = live & shown[7];
  assign char_col   = live ? {addr_q, second} : '0;
endmodule

module dual_char_serializer_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          slot_stb,
  input logic          disp_en,
  input logic [15:0]   mem_data,
  input logic [AW-1:0] slot_addr,
  input logic          char_valid,
  input logic [6:0]    char_glyph,
  input logic          char_rev,
  input logic [AW:0]   char_col
);
  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !char_valid);

  a_r2_low_first: assert property (@(posedge clk) disable iff (!rst_n)
    slot_stb && disp_en |=> char_valid && !char_col[0]
      && char_glyph == $past(mem_data[6:0]) && char_col[AW:1] == $past(slot_addr));

  a_r4_rev_low: assert property (@(posedge clk) disable iff (!rst_n)
    slot_stb && disp_en |=> char_rev == $past(mem_data[7]));

  a_r5_blank_slot: assert property (@(posedge clk) disable iff (!rst_n)
    slot_stb && !disp_en |=> !char_valid);

  a_r6_slot_held: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_stb && char_valid |=> !char_valid || char_col[AW:1] == $past(char_col[AW:1]));

  a_r7_quiet_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !char_valid |-> char_glyph == 7'd0 && !char_rev && char_col == '0);
endmodule

bind dual_char_serializer dual_char_serializer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .disp_en(disp_en),
  .mem_data(mem_data), .slot_addr(slot_addr), .char_valid(char_valid),
  .char_glyph(char_glyph), .char_rev(char_rev), .char_col(char_col)
);

// File: tb/sim_dual_char_serializer.sv
module sim_dual_char_serializer;
  localparam int AW = 6, SLOT_CYC = 4, HALF = SLOT_CYC / 2;

  logic clk = 1'b0, rst_n = 1'b0, slot_stb = 1'b0, disp_en = 1'b0;
  logic [AW-1:0] slot_addr = '0;
  logic [15:0] mem_data = '0;
  logic char_valid, char_rev;
  logic [6:0] char_glyph;
  logic [AW:0] char_col;
  int runs = 0, fails = 0;

  always #10 clk = ~clk;

  dual_char_serializer #(.AW(AW), .SLOT_CYC(SLOT_CYC)) u0 (
    .clk, .rst_n, .slot_stb, .slot_addr, .disp_en, .mem_data,
    .char_valid, .char_glyph, .char_rev, .char_col);

  function automatic logic [15:0] pack(input logic v, input logic [7:0] b, input int col);
    return v ? {1'b1, b[7], 7'(col), b[6:0]} : 16'h0;
  endfunction

  task automatic chk(input string r, input logic [15:0] exp);
    logic [15:0] got = {char_valid, char_rev, char_col, char_glyph};
    runs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", r, got, exp);
    end
  endtask

  task automatic drive_stb(input int a, input logic [15:0] d, input logic en);
    slot_stb = 1'b1; slot_addr = AW'(a); mem_data = d; disp_en = en;
  endtask

  // caller drives the strobe at a negedge; this samples the slot that follows
  task automatic watch_slot(input int a, input logic [15:0] d, input logic en, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (i == 0) begin
        slot_stb = 1'b0; mem_data = ~d ^ 16'h5a3c; slot_addr = ~slot_addr; disp_en = ~en;
      end
      if (!en) chk("R5 blank slot", 16'h0);
      else if (i < HALF) chk("R2 R4 R6 low byte", pack(1'b1, d[7:0], 2 * a));
      else chk("R3 R4 R6 high byte", pack(1'b1, d[15:8], 2 * a + 1));
    end
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog got=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", runs + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 16'h0);

    // sweep every byte value through low and high position, back to back
    for (int s = 0; s < 256; s++) begin
      logic [15:0] d = {8'((s * 7 + 3) & 8'hff), 8'(s)};
      drive_stb(s % 64, d, 1'b1);
      watch_slot(s % 64, d, 1'b1, SLOT_CYC);
    end

    // a full 40-slot line gives columns 0..79
    for (int s = 0; s < 40; s++) begin
      logic [15:0] d = {8'(8'h80 | (2 * s + 1)), 8'(2 * s)};
      drive_stb(s, d, 1'b1);
      watch_slot(s, d, 1'b1, SLOT_CYC);
    end

    // disabled slot between enabled ones
    drive_stb(5, 16'hffff, 1'b0);
    watch_slot(5, 16'hffff, 1'b0, SLOT_CYC);
    drive_stb(6, 16'h8a41, 1'b1);
    watch_slot(6, 16'h8a41, 1'b1, SLOT_CYC);

    // slot lapses with no strobe
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R7 lapsed slot", 16'h0);
    end

    // mid-slot restart
    drive_stb(9, 16'h1234, 1'b1);
    watch_slot(9, 16'h1234, 1'b1, 1);
    drive_stb(10, 16'hc3f1, 1'b1);
    @(negedge clk);
    slot_stb = 1'b0;
    chk("R8 restart low byte", pack(1'b1, 8'hf1, 20));
    @(negedge clk);
    chk("R8 restart still low", pack(1'b1, 8'hf1, 20));
    @(negedge clk);
    chk("R8 restart high byte", pack(1'b1, 8'hc3, 21));
    repeat (2) @(negedge clk);
    chk("R7 lapse after restart", 16'h0);

    // reset mid-slot
    drive_stb(3, 16'h7777, 1'b1);
    @(negedge clk);
    slot_stb = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-slot", 16'h0);

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule